// File: doc/BRIEF.md
# Out-of-Order Burst Read Responder

This block sits on the memory side of a read path. It takes read requests on a valid/ready request channel, each carrying a transaction tag, a start address, a beat count and a modelled access delay. It answers each request with a burst on a valid/ready response channel. Every beat of the burst carries the request's tag, and the last beat is flagged. Each beat carries the start address plus its beat index, so a consumer can tell exactly which request and which beat it is looking at.

Accepted requests wait in a pool of `DEPTH` slots. A request's delay counts down once per cycle. When the delay reaches zero the request may be answered, provided no older pending request carries the same tag. A request that becomes ready early may therefore overtake older requests with other tags, while requests that share a tag always leave in arrival order. When several requests are ready at once, the oldest is served. Bursts are never interleaved: a burst runs to its last beat before the next one begins. With `DEPTH` set to 1 the block answers strictly in arrival order.

Top module: `rd_reorder_slave`

## Requirements
- R1: Bursts for requests that share a tag leave in the order those requests were accepted, whatever their delays.
- R2: A request whose delay has expired is answered ahead of an older, still-waiting request that carries a different tag.
- R3: Every beat carries the tag of the request it answers. Beat k (counting from 0) of a burst carries the request's start address, zero-extended to the data width, plus k.
- R4: A request with beat field n produces exactly n+1 beats, with the last flag set on the final beat only. Once a burst has started, valid stays high until its last beat is taken, and the tag does not change during the burst.
- R5: While a beat is offered and not taken, the valid, tag, data and last outputs hold their values.
- R6: The request channel's ready is low exactly when `DEPTH` accepted requests are waiting and none of them has yet started its burst.
- R7: A request accepted with delay L becomes eligible L cycles after the accepting clock edge. If the response channel is idle and the request is not blocked, its first beat is offered L+1 cycles after that edge.
- R8: With `DEPTH` equal to 1, bursts leave in acceptance order and the request channel does not accept while one request is waiting.
- R9: After reset, valid on the response channel is low and ready on the request channel is high.
- R10: When several requests are eligible at the same time, the one accepted earliest is answered first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ar_valid | input | 1 | Request offered |
| ar_ready | output | 1 | Request slot free |
| ar_id | input | ID_W | Request tag |
| ar_addr | input | ADDR_W | Burst start address |
| ar_len | input | LEN_W | Beats in the burst minus one |
| ar_lat | input | LAT_W | Modelled access delay in cycles |
| r_valid | output | 1 | Beat offered |
| r_ready | input | 1 | Beat taken |
| r_id | output | ID_W | Tag of the request being answered |
| r_data | output | DATA_W | Beat payload (start address plus beat index) |
| r_last | output | 1 | Final beat of the burst |

## Verification
On every cycle the assertions check several properties. Beats stay stable under back-pressure. A burst continues without gaps or tag changes until its last beat, and an idle cycle always follows that last beat. Ready on the request channel tracks an independent count of accepted-but-unstarted requests. The reset values are checked as well. The ordering properties (same-tag order, overtaking across tags, oldest-first choice, the exact delay to the first beat and strict order at depth one) involve whole sequences of requests, so only the bench's scenarios and its scoreboard sweep can show them.

// File: rtl/rro_pkg.sv
package rro_pkg;
  // index width for a pool of n slots, never zero
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rro_pool.sv
module rro_pool
  import rro_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ID_W   = 2,
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 3,
  parameter int LAT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [ID_W-1:0]   push_id,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [LEN_W-1:0]  push_len,
  input  logic [LAT_W-1:0]  push_lat,
  input  logic              pop,
  output logic              full,
  output logic              sel_valid,
  output logic [ID_W-1:0]   sel_id,
  output logic [ADDR_W-1:0] sel_addr,
  output logic [LEN_W-1:0]  sel_len
);
  localparam int IDX_W = idx_width(DEPTH);

  // slot 0 holds the oldest request; slots stay packed toward 0
  logic [DEPTH-1:0]  e_v, n_v;
  logic [ID_W-1:0]   e_id   [DEPTH];
  logic [ID_W-1:0]   n_id   [DEPTH];
  logic [ADDR_W-1:0] e_addr [DEPTH];
  logic [ADDR_W-1:0] n_addr [DEPTH];
  logic [LEN_W-1:0]  e_len  [DEPTH];
  logic [LEN_W-1:0]  n_len  [DEPTH];
  logic [LAT_W-1:0]  e_lat  [DEPTH];
  logic [LAT_W-1:0]  n_lat  [DEPTH];

  logic [DEPTH-1:0] elig;
  logic [IDX_W-1:0] sel_idx;
  logic             placed;

  genvar gi, gj;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_slot
      logic [DEPTH-1:0] older_hit;
      for (gj = 0; gj < DEPTH; gj++) begin : g_cmp
        if (gj < gi) begin : g_older
          assign older_hit[gj] = e_v[gj] && (e_id[gj] == e_id[gi]);
        end else begin : g_younger
          assign older_hit[gj] = 1'b0;
        end
      end
      assign elig[gi] = e_v[gi] && (e_lat[gi] == '0) && !(|older_hit);
    end
  endgenerate

  // lowest eligible slot is the oldest eligible request
  always_comb begin
    sel_valid = 1'b0;
    sel_idx   = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (elig[k]) begin
        sel_valid = 1'b1;
        sel_idx   = IDX_W'(k);
      end
    end
  end

  assign sel_id   = e_id[sel_idx];
  assign sel_addr = e_addr[sel_idx];
  assign sel_len  = e_len[sel_idx];
  assign full     = &e_v;

  always_comb begin
    n_v    = e_v;
    n_id   = e_id;
    n_addr = e_addr;
    n_len  = e_len;
    n_lat  = e_lat;
    placed = 1'b0;
    if (pop) begin
      for (int k = 0; k < DEPTH - 1; k++) begin
        if (k >= int'(sel_idx)) begin
          n_v[k]    = n_v[k+1];
          n_id[k]   = n_id[k+1];
          n_addr[k] = n_addr[k+1];
          n_len[k]  = n_len[k+1];
          n_lat[k]  = n_lat[k+1];
        end
      end
      n_v[DEPTH-1] = 1'b0;
    end
    for (int k = 0; k < DEPTH; k++) begin
      if (n_v[k] && (n_lat[k] != '0)) n_lat[k] = n_lat[k] - LAT_W'(1);
    end
    for (int k = 0; k < DEPTH; k++) begin
      if (push && !placed && !n_v[k]) begin
        n_v[k]    = 1'b1;
        n_id[k]   = push_id;
        n_addr[k] = push_addr;
        n_len[k]  = push_len;
        n_lat[k]  = push_lat;
        placed    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      e_v <= '0;
    end else begin
      e_v <= n_v;
    end
    e_id   <= n_id;
    e_addr <= n_addr;
    e_len  <= n_len;
    e_lat  <= n_lat;
  end
endmodule

// File: rtl/rro_beat.sv
module rro_beat #(
  parameter int ID_W   = 2,
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_valid,
  input  logic [ID_W-1:0]   sel_id,
  input  logic [ADDR_W-1:0] sel_addr,
  input  logic [LEN_W-1:0]  sel_len,
  output logic              take,
  input  logic              r_ready,
  output logic              r_valid,
  output logic [ID_W-1:0]   r_id,
  output logic [DATA_W-1:0] r_data,
  output logic              r_last
);
  logic [LEN_W-1:0] left;

  // a new burst is loaded only when no burst is on the channel
  assign take = sel_valid && !r_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      r_valid <= 1'b0;
      r_last  <= 1'b0;
      r_id    <= '0;
      r_data  <= '0;
      left    <= '0;
    end else if (take) begin
      r_valid <= 1'b1;
      r_id    <= sel_id;
      r_data  <= DATA_W'(sel_addr);
      left    <= sel_len;
      r_last  <= (sel_len == '0);
    end else if (r_valid && r_ready) begin
      if (r_last) begin
        r_valid <= 1'b0;
        r_last  <= 1'b0;
      end else begin
        r_data <= r_data + DATA_W'(1);
        left   <= left - LEN_W'(1);
        r_last <= (left == LEN_W'(1));
      end
    end
  end
endmodule

// File: rtl/rd_reorder_slave.sv
module rd_reorder_slave #(
  parameter int DEPTH  = 4,
  parameter int ID_W   = 2,
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 3,
  parameter int DATA_W = 16,
  parameter int LAT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ar_valid,
  output logic              ar_ready,
  input  logic [ID_W-1:0]   ar_id,
  input  logic [ADDR_W-1:0] ar_addr,
  input  logic [LEN_W-1:0]  ar_len,
  input  logic [LAT_W-1:0]  ar_lat,
  output logic              r_valid,
  input  logic              r_ready,
  output logic [ID_W-1:0]   r_id,
  output logic [DATA_W-1:0] r_data,
  output logic              r_last
);
  logic              full, sel_valid, take;
  logic [ID_W-1:0]   sel_id;
  logic [ADDR_W-1:0] sel_addr;
  logic [LEN_W-1:0]  sel_len;

  assign ar_ready = !full;

  rro_pool #(
    .DEPTH(DEPTH), .ID_W(ID_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LAT_W(LAT_W)
  ) u_pool (
    .clk(clk), .rst(rst),
    .push(ar_valid && ar_ready), .push_id(ar_id), .push_addr(ar_addr),
    .push_len(ar_len), .push_lat(ar_lat),
    .pop(take), .full(full), .sel_valid(sel_valid),
    .sel_id(sel_id), .sel_addr(sel_addr), .sel_len(sel_len)
  );

  rro_beat #(
    .ID_W(ID_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)
  ) u_beat (
    .clk(clk), .rst(rst),
    .sel_valid(sel_valid), .sel_id(sel_id), .sel_addr(sel_addr), .sel_len(sel_len),
    .take(take), .r_ready(r_ready), .r_valid(r_valid), .r_id(r_id),
    .r_data(r_data), .r_last(r_last)
  );
endmodule

// File: rtl/rro_checker.sv
module rro_checker #(
  parameter int DEPTH  = 4,
  parameter int ID_W   = 2,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              ar_valid,
  input logic              ar_ready,
  input logic              r_valid,
  input logic              r_ready,
  input logic [ID_W-1:0]   r_id,
  input logic [DATA_W-1:0] r_data,
  input logic              r_last
);
  localparam int OCC_W = $clog2(DEPTH + 1) + 1;

  logic             valid_q, rst_q, start_now;
  logic [OCC_W-1:0] occ, occ_eff;

  assign start_now = r_valid && !valid_q;
  assign occ_eff   = occ - OCC_W'(start_now);

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      valid_q <= 1'b0;
      occ     <= '0;
    end else begin
      valid_q <= r_valid;
      occ     <= occ_eff + OCC_W'(ar_valid && ar_ready);
    end
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_id) && $stable(r_data) && $stable(r_last)));

  assert_burst_runs_R4: assert property (@(posedge clk) disable iff (rst)
    (r_valid && r_ready && !r_last) |=> (r_valid && $stable(r_id)));

  assert_gap_after_last_R4: assert property (@(posedge clk) disable iff (rst)
    (r_valid && r_ready && r_last) |=> !r_valid);

  assert_ready_tracks_pool_R6: assert property (@(posedge clk) disable iff (rst)
    ar_ready == (occ_eff != OCC_W'(DEPTH)));

  assert_no_phantom_burst_R7: assert property (@(posedge clk) disable iff (rst)
    start_now |-> (occ != '0));

  always_ff @(posedge clk) begin
    if (rst_q && !rst) begin
      assert_reset_values_R9: assert (!r_valid && ar_ready)
        else $error("reset values wrong");
    end
  end
endmodule

bind rd_reorder_slave rro_checker #(.DEPTH(DEPTH), .ID_W(ID_W), .DATA_W(DATA_W)) u_rro_chk (.*);

// File: tb/tb_rd_reorder_slave.sv
module tb_rd_reorder_slave;
  localparam int DEPTH  = 4;
  localparam int ID_W   = 2;
  localparam int ADDR_W = 10;
  localparam int LEN_W  = 3;
  localparam int DATA_W = 16;
  localparam int LAT_W  = 4;
  localparam int NID    = 1 << ID_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic              ar_valid = 1'b0, ar_ready;
  logic [ID_W-1:0]   ar_id = '0;
  logic [ADDR_W-1:0] ar_addr = '0;
  logic [LEN_W-1:0]  ar_len = '0;
  logic [LAT_W-1:0]  ar_lat = '0;
  logic              r_valid, r_ready = 1'b0, r_last;
  logic [ID_W-1:0]   r_id;
  logic [DATA_W-1:0] r_data;

  logic              b_ar_valid = 1'b0, b_ar_ready;
  logic [ID_W-1:0]   b_ar_id = '0;
  logic [ADDR_W-1:0] b_ar_addr = '0;
  logic [LEN_W-1:0]  b_ar_len = '0;
  logic [LAT_W-1:0]  b_ar_lat = '0;
  logic              b_r_valid, b_r_ready = 1'b1, b_r_last;
  logic [ID_W-1:0]   b_r_id;
  logic [DATA_W-1:0] b_r_data;

  rd_reorder_slave #(.DEPTH(DEPTH), .ID_W(ID_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
                     .DATA_W(DATA_W), .LAT_W(LAT_W)) dut (
    .clk(clk), .rst(rst), .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id),
    .ar_addr(ar_addr), .ar_len(ar_len), .ar_lat(ar_lat), .r_valid(r_valid),
    .r_ready(r_ready), .r_id(r_id), .r_data(r_data), .r_last(r_last));

  rd_reorder_slave #(.DEPTH(1), .ID_W(ID_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
                     .DATA_W(DATA_W), .LAT_W(LAT_W)) dut_inorder (
    .clk(clk), .rst(rst), .ar_valid(b_ar_valid), .ar_ready(b_ar_ready), .ar_id(b_ar_id),
    .ar_addr(b_ar_addr), .ar_len(b_ar_len), .ar_lat(b_ar_lat), .r_valid(b_r_valid),
    .r_ready(b_r_ready), .r_id(b_r_id), .r_data(b_r_data), .r_last(b_r_last));

  int tests = 0, fails = 0, cyc = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard: per-tag queues of accepted requests
  logic [ADDR_W-1:0] q_addr [NID][64];
  logic [LEN_W-1:0]  q_len  [NID][64];
  int q_hd [NID];
  int q_tl [NID];
  logic [ADDR_W-1:0] log_addr [256];
  int nlog = 0, mbeat = 0, beats_seen = 0, mid = 0, acc_cyc = 0;
  logic [ADDR_W-1:0] cur_a;
  logic [LEN_W-1:0]  cur_l;

  initial for (int i = 0; i < NID; i++) begin q_hd[i] = 0; q_tl[i] = 0; end

  always @(negedge clk) begin
    if (!rst && r_valid && r_ready) begin
      mid = int'(r_id);
      if (mbeat == 0) begin
        if (q_hd[mid] == q_tl[mid]) begin
          chk(1'b0, "R1 burst with no pending request of its tag", mid, -1);
          cur_a = '0; cur_l = '0;
        end else begin
          cur_a = q_addr[mid][q_hd[mid] % 64];
          cur_l = q_len[mid][q_hd[mid] % 64];
        end
      end
      chk(r_data == DATA_W'(cur_a) + DATA_W'(mbeat), "R3 tag/data of beat",
          r_data, DATA_W'(cur_a) + DATA_W'(mbeat));
      chk(r_last == (mbeat == int'(cur_l)), "R4 last flag position", r_last, mbeat == int'(cur_l));
      beats_seen++;
      if (r_last) begin
        q_hd[mid]++;
        log_addr[nlog % 256] = cur_a;
        nlog++;
        mbeat = 0;
      end else mbeat++;
    end
  end

  task automatic send(input int id, input int addr, input int len, input int lat);
    @(negedge clk);
    ar_id = ID_W'(id); ar_addr = ADDR_W'(addr); ar_len = LEN_W'(len); ar_lat = LAT_W'(lat);
    ar_valid = 1'b1;
    while (!ar_ready) @(negedge clk);
    @(posedge clk);
    q_addr[id][q_tl[id] % 64] = ADDR_W'(addr);
    q_len[id][q_tl[id] % 64]  = LEN_W'(len);
    q_tl[id]++;
    #1;
    acc_cyc = cyc;
    ar_valid = 1'b0;
  endtask

  function automatic bit all_empty();
    for (int i = 0; i < NID; i++) if (q_hd[i] != q_tl[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic drain();
    int t = 0;
    @(negedge clk);
    while (!(all_empty() && !r_valid) && t < 3000) begin @(negedge clk); t++; end
    chk(t < 3000, "R4 all requests answered", t, 0);
  endtask

  logic [15:0] lfsr = 16'hACE1;
  function automatic logic [15:0] step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // depth-one instance: log first-beat data of each burst
  logic [DATA_W-1:0] b_log [4];
  int b_n = 0;
  bit b_first = 1'b1;
  always @(negedge clk) begin
    if (!rst && b_r_valid && b_r_ready) begin
      if (b_first && b_n < 4) begin b_log[b_n] = b_r_data; b_n++; end
      b_first = b_r_last;
    end
  end

  initial begin
    int base, t, exp_beats;
    logic [DATA_W-1:0] held;
    bit sweep_on;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(ar_ready == 1'b1, "R9 request ready after reset", ar_ready, 1);
    chk(r_valid == 1'b0, "R9 no beat after reset", r_valid, 0);

    // R7: delay 5, idle channel -> first beat offered 6 cycles after accept edge
    r_ready = 1'b1;
    send(0, 16, 0, 5);
    t = acc_cyc;
    @(negedge clk);
    while (!r_valid && cyc < t + 40) @(negedge clk);
    chk(cyc == t + 6, "R7 first beat delay", cyc - t, 6);
    drain();

    // zero delay -> one cycle
    send(1, 24, 1, 0);
    t = acc_cyc;
    @(negedge clk);
    while (!r_valid && cyc < t + 40) @(negedge clk);
    chk(cyc == t + 1, "R7 zero delay", cyc - t, 1);
    drain();

    // R2 and R1: slow tag0, fast tag1, fast tag0 behind slow tag0
    base = nlog;
    send(0, 32, 2, 12);
    send(1, 40, 1, 0);
    send(0, 48, 0, 0);
    drain();
    chk(log_addr[base] == 40, "R2 different tag overtakes", log_addr[base], 40);
    chk(log_addr[base+1] == 32, "R1 same-tag order (first)", log_addr[base+1], 32);
    chk(log_addr[base+2] == 48, "R1 same-tag order (second)", log_addr[base+2], 48);

    // R10 and R5: stall channel, three ready requests
    r_ready = 1'b0;
    base = nlog;
    send(1, 56, 1, 0);
    send(2, 64, 0, 0);
    send(3, 72, 0, 0);
    @(negedge clk);
    while (!r_valid) @(negedge clk);
    held = r_data;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(r_valid && r_data == held, "R5 beat held under stall", r_data, held);
    end
    r_ready = 1'b1;
    drain();
    chk(log_addr[base] == 56, "R10 oldest first (1)", log_addr[base], 56);
    chk(log_addr[base+1] == 64, "R10 oldest first (2)", log_addr[base+1], 64);
    chk(log_addr[base+2] == 72, "R10 oldest first (3)", log_addr[base+2], 72);

    // R6: fill the pool with slow requests
    r_ready = 1'b0;
    for (int i = 0; i < DEPTH; i++) send(i, 80 + 8 * i, 0, 15);
    @(negedge clk);
    chk(ar_ready == 1'b0, "R6 ready low when pool full", ar_ready, 0);
    t = 0;
    while (!ar_ready && t < 40) begin @(negedge clk); t++; end
    chk(ar_ready == 1'b1, "R6 ready returns after a burst starts", ar_ready, 1);
    r_ready = 1'b1;
    drain();

    // sweep with random back-pressure
    exp_beats = beats_seen;
    sweep_on = 1'b1;
    fork
      begin
        for (int i = 0; i < 48; i++) begin
          lfsr = step(lfsr); lfsr = step(lfsr);
          send(int'(lfsr[1:0]), 128 + 8 * i, int'(lfsr[4:2]), int'(lfsr[8:5]));
          exp_beats += int'(lfsr[4:2]) + 1;
        end
        sweep_on = 1'b0;
      end
      begin
        logic [15:0] rr = 16'h1D2B;
        while (sweep_on) begin
          @(posedge clk); #2;
          rr = step(rr);
          r_ready = rr[0] | rr[3];
        end
      end
    join
    r_ready = 1'b1;
    drain();
    chk(beats_seen == exp_beats, "R4 total beats in sweep", beats_seen, exp_beats);

    // R8: depth-one instance keeps acceptance order
    @(negedge clk);
    b_ar_id = 0; b_ar_addr = 10'h40; b_ar_len = 1; b_ar_lat = 9; b_ar_valid = 1'b1;
    while (!b_ar_ready) @(negedge clk);
    @(posedge clk); #1 b_ar_valid = 1'b0;
    @(negedge clk);
    chk(b_ar_ready == 1'b0, "R8 depth-one blocks while waiting", b_ar_ready, 0);
    b_ar_id = 1; b_ar_addr = 10'h80; b_ar_len = 0; b_ar_lat = 0; b_ar_valid = 1'b1;
    while (!b_ar_ready) @(negedge clk);
    @(posedge clk); #1 b_ar_valid = 1'b0;
    t = 0;
    while (b_n < 2 && t < 100) begin @(negedge clk); t++; end
    chk(b_n == 2 && b_log[0] == 16'h40, "R8 first burst in order", b_log[0], 16'h40);
    chk(b_n == 2 && b_log[1] == 16'h80, "R8 second burst in order", b_log[1], 16'h80);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule